// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that finishes every instruction in exactly one clock. It supports six operations: unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-on-equal. The core contains the program counter, a 32-entry by 32-bit register file, the immediate extender, an add/subtract/OR unit and the steering multiplexers. Instruction fetch and data access go through two memory ports. The memories outside the core return read data combinationally in the same cycle and commit writes on the rising clock edge.

Every instruction is 32 bits wide. The fields sit at fixed positions: opcode in [31:26], first source index (rs) in [25:21], second source or load/immediate destination index (rt) in [20:16], register-form destination index (rd) in [15:11], shift amount in [10:6], function code in [5:0] and a 16-bit immediate in [15:0]. All addresses are byte addresses. Word accesses use address bits [31:2]. The core drives address bits [1:0] but never uses them itself.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the core performs no register write and no memory write. After the first rising edge with `rst` high, `imem_addr` is 0. The reset is synchronous and active high.
- R2: Opcode 0x00 with shift field 0 and function 0x21 writes rs+rt into register rd, modulo 2^32. With function 0x23 it writes rs-rt into register rd, modulo 2^32.
- R3: Opcode 0x0D writes rs OR the zero-extended immediate into register rt.
- R4: Opcode 0x23 writes into register rt the data word at byte address rs + sign-extended immediate. A value written by one instruction is visible to the next instruction.
- R5: Opcode 0x2B raises `dmem_we` for that single cycle. It drives `dmem_addr` with rs + sign-extended immediate and `dmem_wdata` with register rt.
- R6: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise the next PC is PC + 4. Backward offsets are supported.
- R7: Every instruction other than a taken branch advances the PC by 4, and the PC always stays word aligned.
- R8: Register 0 always reads as zero. Writes to it by OR-immediate, add or load have no effect.
- R9: Any unsupported opcode, any unsupported function code, and any register-form word with a nonzero shift field is a no-op. A no-op causes no register write and no memory write, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally for `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data write strobe, high only for a store outside reset |
| dmem_rdata | input | 32 | Data word returned combinationally for `dmem_addr` |

## Verification
Short programs are placed in the bench's instruction memory. Their results are observed through stores and the fetch address. Immediates with bit 15 set tell zero extension apart from sign extension, and the add/subtract tests include a wrap through zero that exposes any carry or width mistake. The branch tests use one equal pair, one unequal pair and a three-pass backward loop, which separates a wrong offset scale or sign from a wrong condition. A set of malformed words, together with writes aimed at register 0, shows whether decode is strict and whether register 0 is protected.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 16;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;

    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUBU = 6'h23;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;
    typedef enum logic {EXT_ZERO, EXT_SIGN} ext_e;
    typedef enum logic {SRCB_REG, SRCB_IMM} srcb_e;
    typedef enum logic {WB_ALU, WB_MEM} wb_e;
    typedef enum logic {DST_RT, DST_RD} dst_e;

    typedef struct packed {
        logic [5:0]        opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } insn_t;

    typedef struct packed {
        alu_op_e alu_op;
        ext_e    ext;
        srcb_e   srcb;
        wb_e     wb;
        dst_e    dst;
        logic    reg_we;
        logic    mem_we;
        logic    is_branch;
    } ctrl_t;

    function automatic logic [IMM_W-1:0] imm_of(insn_t f);
        return {f.rd, f.shamt, f.funct};
    endfunction

    function automatic logic [XLEN-1:0] extend(logic [IMM_W-1:0] imm, ext_e mode);
        logic [XLEN-1:0] r;
        if (mode == EXT_SIGN) r = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        else                  r = {{(XLEN-IMM_W){1'b0}}, imm};
        return r;
    endfunction

    function automatic ctrl_t decode(insn_t f);
        ctrl_t c;
        c.alu_op    = ALU_ADD;
        c.ext       = EXT_SIGN;
        c.srcb      = SRCB_REG;
        c.wb        = WB_ALU;
        c.dst       = DST_RD;
        c.reg_we    = 1'b0;
        c.mem_we    = 1'b0;
        c.is_branch = 1'b0;
        case (f.opc)
            OPC_REG: begin
                if (f.shamt == 5'd0) begin
                    case (f.funct)
                        FN_ADDU: c.reg_we = 1'b1;
                        FN_SUBU: begin
                            c.alu_op = ALU_SUB;
                            c.reg_we = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            OPC_ORI: begin
                c.alu_op = ALU_OR;
                c.ext    = EXT_ZERO;
                c.srcb   = SRCB_IMM;
                c.dst    = DST_RT;
                c.reg_we = 1'b1;
            end
            OPC_LOAD: begin
                c.srcb   = SRCB_IMM;
                c.wb     = WB_MEM;
                c.dst    = DST_RT;
                c.reg_we = 1'b1;
            end
            OPC_STOR: begin
                c.srcb   = SRCB_IMM;
                c.mem_we = 1'b1;
            end
            OPC_BEQ: begin
                c.alu_op    = ALU_SUB;
                c.is_branch = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NUM_REGS = 32,
    parameter int DW       = 32
) (
    input  logic                        clk,
    input  logic [$clog2(NUM_REGS)-1:0] ra,
    input  logic [$clog2(NUM_REGS)-1:0] rb,
    input  logic [$clog2(NUM_REGS)-1:0] wa,
    input  logic                        we,
    input  logic [DW-1:0]               wd,
    output logic [DW-1:0]               rda,
    output logic [DW-1:0]               rdb
);
    localparam int AW = $clog2(NUM_REGS);

    logic [NUM_REGS*DW-1:0] flat;

    // Entry 0 has no storage and is tied to zero.
    assign flat[DW-1:0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (wa == AW'(i))) q <= wd;
        end
        assign flat[i*DW +: DW] = q;
    end

    assign rda = flat[ra*DW +: DW];
    assign rdb = flat[rb*DW +: DW];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
    parameter int          AW       = 32,
    parameter int          OFF_W    = 16,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_br,
    input  logic [OFF_W-1:0] br_off,
    output logic [AW-1:0]    pc
);
    localparam int          STEP_SH = 2;
    localparam logic [AW-1:0] STEP  = AW'(1 << STEP_SH);
    localparam int          PAD     = AW - OFF_W - STEP_SH;

    logic [AW-1:0] seq_pc;
    logic [AW-1:0] off_bytes;
    logic [AW-1:0] nxt_pc;

    assign seq_pc    = pc + STEP;
    assign off_bytes = {{PAD{br_off[OFF_W-1]}}, br_off, {STEP_SH{1'b0}}};
    assign nxt_pc    = take_br ? (seq_pc + off_bytes) : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC[AW-1:0];
        else     pc <= nxt_pc;
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int          NUM_REGS = 1 << RIDX_W,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    insn_t           ins;
    ctrl_t           ctl;
    logic [XLEN-1:0] busa, busb, ext_imm, opb, alu_y, wb_data;
    logic            alu_zero, take_br, rf_we;
    logic [RIDX_W-1:0] dst_idx;

    assign ins = insn_t'(imem_rdata);
    assign ctl = decode(ins);

    sc_regfile #(.NUM_REGS(NUM_REGS), .DW(XLEN)) u_rf (
        .clk (clk),
        .ra  (ins.rs),
        .rb  (ins.rt),
        .wa  (dst_idx),
        .we  (rf_we),
        .wd  (wb_data),
        .rda (busa),
        .rdb (busb)
    );

    assign ext_imm = extend(imm_of(ins), ctl.ext);
    assign opb     = (ctl.srcb == SRCB_IMM) ? ext_imm : busb;

    sc_alu #(.DW(XLEN)) u_alu (
        .a    (busa),
        .b    (opb),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dst_idx = (ctl.dst == DST_RD) ? ins.rd : ins.rt;
    assign wb_data = (ctl.wb == WB_MEM) ? dmem_rdata : alu_y;
    assign rf_we   = ctl.reg_we & ~rst;
    assign take_br = ctl.is_branch & alu_zero;

    sc_pc_unit #(.AW(XLEN), .OFF_W(IMM_W), .RESET_PC(RESET_PC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .take_br (take_br),
        .br_off  (imm_of(ins)),
        .pc      (imem_addr)
    );

    assign dmem_addr  = alu_y;
    assign dmem_wdata = busb;
    assign dmem_we    = ctl.mem_we & ~rst;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] ins,
    input logic            st_en,
    input logic [XLEN-1:0] st_addr,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b
);
    logic            rst_d;
    logic [XLEN-1:0] sext_imm;

    assign sext_imm = {{(XLEN-IMM_W){ins[15]}}, ins[15:0]};

    always_ff @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            // R1
            reset_pc_chk: assert (pc == '0);
        end
        if (rst === 1'b1) begin
            // R1
            reset_quiet_chk: assert (!st_en);
        end
    end

    // R7
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ins[31:26] != OPC_BEQ) |=> pc == $past(pc) + 32'd4);

    // R6
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (ins[31:26] == OPC_BEQ && src_a == src_b) |=>
        pc == $past(pc) + 32'd4 + {$past(sext_imm[XLEN-3:0]), 2'b00});

    // R6
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (ins[31:26] == OPC_BEQ && src_a != src_b) |=> pc == $past(pc) + 32'd4);

    // R5
    st_only_chk: assert property (@(posedge clk) disable iff (rst)
        st_en |-> ins[31:26] == OPC_STOR);

    // R5
    st_addr_chk: assert property (@(posedge clk) disable iff (rst)
        st_en |-> st_addr == src_a + sext_imm);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (imem_addr),
    .ins     (imem_rdata),
    .st_en   (dmem_we),
    .st_addr (dmem_addr),
    .src_a   (busa),
    .src_b   (busb)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [0:63];
    logic [31:0] dmem [0:63];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sc_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    localparam logic [5:0] O_BEQ = 6'h04, O_ORI = 6'h0D, O_LW = 6'h23, O_SW = 6'h2B;
    localparam logic [5:0] F_ADD = 6'h21, F_SUB = 6'h23;

    function automatic logic [31:0] rt_op(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] im_op(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        imem[0] = im_op(O_SW, 5'd0, 5'd0, 16'h0);
        dmem[0] = 32'hDEAD_BEEF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'h0);
        chk("R1 no store in reset", {31'b0, dmem_we}, 32'h0);
        chk("R1 memory untouched in reset", dmem[0], 32'hDEAD_BEEF);
        rst = 1'b0;
        run(1);
        chk("R5 store of r0 after reset", dmem[0], 32'h0);
    endtask

    task automatic t_ori_store();
        clear_mem();
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'h1234);
        imem[1] = im_op(O_ORI, 5'd0, 5'd2, 16'hFFFF);
        imem[2] = im_op(O_SW, 5'd0, 5'd1, 16'h0000);
        imem[3] = im_op(O_SW, 5'd0, 5'd2, 16'h0004);
        start();
        run(2);
        chk("R5 store strobe", {31'b0, dmem_we}, 32'h1);
        chk("R5 store address", dmem_addr, 32'h0);
        chk("R5 store data", dmem_wdata, 32'h1234);
        run(2);
        chk("R3 ori small", dmem[0], 32'h0000_1234);
        chk("R3 ori zero-extend", dmem[1], 32'h0000_FFFF);
        chk("R7 pc after four", imem_addr, 32'd16);
    endtask

    task automatic t_arith();
        clear_mem();
        dmem[5] = 32'hAAAA_AAAA;
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'h1234);
        imem[1] = im_op(O_ORI, 5'd0, 5'd2, 16'hFFFF);
        imem[2] = rt_op(F_ADD, 5'd1, 5'd2, 5'd3);
        imem[3] = rt_op(F_SUB, 5'd1, 5'd2, 5'd4);
        imem[4] = im_op(O_SW, 5'd0, 5'd3, 16'd8);
        imem[5] = im_op(O_SW, 5'd0, 5'd4, 16'd12);
        imem[6] = rt_op(F_SUB, 5'd0, 5'd2, 5'd6);
        imem[7] = rt_op(F_ADD, 5'd6, 5'd2, 5'd7);
        imem[8] = im_op(O_SW, 5'd0, 5'd6, 16'd16);
        imem[9] = im_op(O_SW, 5'd0, 5'd7, 16'd20);
        start();
        run(10);
        chk("R2 add", dmem[2], 32'h0001_1233);
        chk("R2 sub negative", dmem[3], 32'hFFFF_1235);
        chk("R2 sub from zero", dmem[4], 32'hFFFF_0001);
        chk("R2 add wraps to zero", dmem[5], 32'h0);
    endtask

    task automatic t_load();
        clear_mem();
        dmem[10] = 32'hCAFE_F00D;
        dmem[2]  = 32'h1357_2468;
        imem[0] = im_op(O_ORI, 5'd0, 5'd6, 16'd44);
        imem[1] = im_op(O_LW, 5'd6, 5'd7, 16'hFFFC);
        imem[2] = im_op(O_SW, 5'd0, 5'd7, 16'd48);
        imem[3] = im_op(O_LW, 5'd0, 5'd9, 16'd8);
        imem[4] = im_op(O_SW, 5'd0, 5'd9, 16'd52);
        start();
        run(5);
        chk("R4 load negative offset", dmem[12], 32'hCAFE_F00D);
        chk("R4 load positive offset", dmem[13], 32'h1357_2468);
    endtask

    task automatic t_zero();
        clear_mem();
        dmem[0] = 32'h99;
        dmem[2] = 32'hAAAA;
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'h0077);
        imem[1] = im_op(O_ORI, 5'd0, 5'd0, 16'h0055);
        imem[2] = rt_op(F_ADD, 5'd1, 5'd1, 5'd0);
        imem[3] = im_op(O_LW, 5'd0, 5'd0, 16'd0);
        imem[4] = im_op(O_SW, 5'd0, 5'd0, 16'd8);
        start();
        run(5);
        chk("R8 register zero stays zero", dmem[2], 32'h0);
    endtask

    task automatic t_branch(bit equal);
        clear_mem();
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'd5);
        imem[1] = im_op(O_ORI, 5'd0, 5'd2, equal ? 16'd5 : 16'd6);
        imem[2] = im_op(O_ORI, 5'd0, 5'd3, 16'h600D);
        imem[3] = im_op(O_BEQ, 5'd1, 5'd2, 16'd1);
        imem[4] = im_op(O_ORI, 5'd0, 5'd3, 16'h0BAD);
        imem[5] = im_op(O_SW, 5'd0, 5'd3, 16'd0);
        start();
        run(4);
        if (equal) begin
            chk("R6 taken target", imem_addr, 32'd20);
            run(1);
            chk("R6 taken skips", dmem[0], 32'h600D);
        end else begin
            chk("R6 not-taken target", imem_addr, 32'd16);
            run(2);
            chk("R6 not-taken falls through", dmem[0], 32'h0BAD);
        end
    endtask

    task automatic t_loop();
        clear_mem();
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'd3);
        imem[1] = im_op(O_ORI, 5'd0, 5'd4, 16'd1);
        imem[2] = im_op(O_ORI, 5'd0, 5'd5, 16'd0);
        imem[3] = rt_op(F_SUB, 5'd1, 5'd4, 5'd1);
        imem[4] = rt_op(F_ADD, 5'd5, 5'd4, 5'd5);
        imem[5] = im_op(O_BEQ, 5'd1, 5'd0, 16'd1);
        imem[6] = im_op(O_BEQ, 5'd0, 5'd0, 16'hFFFC);
        imem[7] = im_op(O_SW, 5'd0, 5'd5, 16'd0);
        start();
        run(15);
        chk("R6 backward loop count", dmem[0], 32'd3);
        chk("R6 loop exit pc", imem_addr, 32'd32);
    endtask

    task automatic t_illegal();
        clear_mem();
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'h0077);
        imem[1] = im_op(6'h3F, 5'd1, 5'd1, 16'h00FF);
        imem[2] = rt_op(6'h20, 5'd1, 5'd1, 5'd1);
        imem[3] = {6'h00, 5'd1, 5'd1, 5'd1, 5'd3, F_ADD};
        imem[4] = im_op(6'h28, 5'd0, 5'd1, 16'h0);
        imem[5] = im_op(O_SW, 5'd0, 5'd1, 16'd0);
        start();
        run(1);
        for (int k = 0; k < 4; k++) begin
            chk("R9 no store on unsupported word", {31'b0, dmem_we}, 32'h0);
            run(1);
        end
        chk("R9 pc advanced past no-ops", imem_addr, 32'd20);
        run(1);
        chk("R9 register untouched", dmem[0], 32'h77);
    endtask

    task automatic t_midreset();
        clear_mem();
        imem[0] = im_op(O_ORI, 5'd0, 5'd1, 16'd1);
        start();
        run(5);
        chk("R7 straight-line pc", imem_addr, 32'd20);
        rst = 1'b1;
        run(1);
        chk("R1 pc cleared mid-run", imem_addr, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_ori_store();
        t_arith();
        t_load();
        t_zero();
        t_branch(1'b1);
        t_branch(1'b0);
        t_loop();
        t_illegal();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule